// File: doc/BRIEF.md
# Cascaded LED Driver Chain Refresher

This block sits on the host side of a daisy chain of serial-in LED driver devices, each holding eight on/off channels. It receives a complete picture of the chain as one parallel word through a valid/ready handshake. It then clocks that word out on a single data wire with a shift clock that it generates itself. When the last bit is in place, it raises a strobe so that every device in the chain loads its new outputs together.

All shift-clock phases, the pause before the strobe and the strobe width are whole numbers of system-clock cycles, and each is set by a parameter. The top level checks these counts against the minimum pulse widths and the data setup and hold times of the drivers at elaboration, and stops with an error if any count is too short. A separate blanking input drives the shared active-low output enable line with one cycle of delay, whatever the sequencer is doing at that moment.

Top module: `led_chain_ctrl`

## Requirements
- R1: `frame_ready` is high only while the block is idle. A frame is taken on a cycle where `frame_valid` and `frame_ready` are both high. A `frame_valid` or `frame_data` applied while `frame_ready` is low has no effect on the frame being sent.
- R2: Bit `d*CH_PER_DEV + k` of `frame_data` is channel k of device d, where device 0 is the one wired to `sdata`. Bits leave most significant first, so the farthest device's channel 7 goes out first and bit 0 goes out last.
- R3: During a frame, each bit gets one shift-clock period: `sclk` is low for HALF_CYC cycles and then high for HALF_CYC cycles. There are exactly `N_DEV*CH_PER_DEV` rising edges per frame, and `sclk` stays low when no frame is being sent.
- R4: `sdata` changes only at the falling edge of `sclk` and stays constant for the whole 2*HALF_CYC-cycle window of its bit. This gives HALF_CYC cycles of setup and HALF_CYC cycles of hold around each rising edge.
- R5: `latch` stays low while bits are shifting. It rises GAP_CYC cycles after the last falling edge of `sclk` and stays high for exactly LATCH_CYC cycles.
- R6: `done` is high for exactly one cycle, the first cycle after the last high cycle of `latch`. That cycle is `2*HALF_CYC*N_DEV*CH_PER_DEV + GAP_CYC + LATCH_CYC` cycles after the accepting edge, and `frame_ready` is high again in the same cycle.
- R7: `oe_n` equals the value `blank_in` had one clock earlier. This holds in every state, including during the strobe.
- R8: While `rst` is high, `oe_n` is 1, `frame_ready` is 1, and `sclk`, `latch` and `done` are 0. After reset, `sdata` is 0 until the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | A frame is offered |
| frame_ready | output | 1 | Block is idle and will take a frame |
| frame_data | input | N_DEV*CH_PER_DEV | On/off bit for every channel of the chain |
| blank_in | input | 1 | Force all driver outputs off |
| sdata | output | 1 | Serial data to the nearest device |
| sclk | output | 1 | Generated shift clock |
| latch | output | 1 | Load strobe, active high |
| oe_n | output | 1 | Shared output enable, active low |
| done | output | 1 | One-cycle pulse after the strobe ends |

## Verification
The blanking path and the strobe can act in the same cycle, and the end-of-frame `done` pulse can coincide with a blanking change. The bench toggles `blank_in` in a fixed pattern that covers the strobe window and the `done` cycle. In each of those cycles it judges `oe_n` against the value it drove one cycle earlier, while it also checks `latch`, `done` and `frame_ready` against their computed windows. A second pairing is a new offer that arrives while a frame is being shifted: the bench holds `frame_valid` high with inverted data during the shift and requires the original bits on `sdata` and `frame_ready` low.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_GAP   = 2'd2,
        PH_LATCH = 2'd3
    } phase_e;

    // smallest number of cycles of length per_ns covering ns
    function automatic int ns_cycles(input int ns, input int per_ns);
        return (ns + per_ns - 1) / per_ns;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // driver minimums in nanoseconds
    localparam int HALF_MIN_NS  = 25;
    localparam int STROBE_MIN_NS = 50;
    localparam int SETUP_MIN_NS  = 10;

endpackage

// File: rtl/lcc_serializer.sv
module lcc_serializer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic         sout
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (adv) begin
            sreg <= {sreg[W-2:0], 1'b0};
        end
    end

    assign sout = sreg[W-1];
endmodule

// File: rtl/lcc_sequencer.sv
module lcc_sequencer
    import lcc_pkg::*;
#(
    parameter int W     = 16,
    parameter int HALF  = 3,
    parameter int GAP   = 5,
    parameter int LATCH = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic adv,
    output logic sclk,
    output logic latch,
    output logic done
);
    localparam int MAXC = max3(HALF, GAP, LATCH);
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] H_LAST = CW'(HALF - 1);
    localparam logic [CW-1:0] G_LAST = CW'(GAP - 1);
    localparam logic [CW-1:0] L_LAST = CW'(LATCH - 1);
    localparam logic [BW-1:0] B_LAST = BW'(W - 1);

    phase_e        state;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bitcnt;
    logic          sclk_q, latch_q, done_q;
    logic          cnt_last, last_bit;

    always_comb begin
        unique case (state)
            PH_SHIFT: cnt_last = (cnt == H_LAST);
            PH_GAP:   cnt_last = (cnt == G_LAST);
            PH_LATCH: cnt_last = (cnt == L_LAST);
            default:  cnt_last = 1'b0;
        endcase
    end

    assign last_bit = (bitcnt == B_LAST);
    assign in_ready = (state == PH_IDLE);
    assign load     = in_ready && in_valid;
    assign adv      = (state == PH_SHIFT) && cnt_last && sclk_q && !last_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PH_IDLE;
            cnt     <= '0;
            bitcnt  <= '0;
            sclk_q  <= 1'b0;
            latch_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (load) begin
                        state  <= PH_SHIFT;
                        cnt    <= '0;
                        bitcnt <= '0;
                        sclk_q <= 1'b0;
                    end
                end
                PH_SHIFT: begin
                    if (cnt_last) begin
                        cnt    <= '0;
                        sclk_q <= ~sclk_q;
                        if (sclk_q) begin
                            if (last_bit) state <= PH_GAP;
                            else          bitcnt <= bitcnt + BW'(1);
                        end
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_GAP: begin
                    if (cnt_last) begin
                        cnt     <= '0;
                        latch_q <= 1'b1;
                        state   <= PH_LATCH;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_LATCH: begin
                    if (cnt_last) begin
                        cnt     <= '0;
                        latch_q <= 1'b0;
                        done_q  <= 1'b1;
                        state   <= PH_IDLE;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    assign sclk  = sclk_q;
    assign latch = latch_q;
    assign done  = done_q;
endmodule

// File: rtl/led_chain_ctrl.sv
module led_chain_ctrl
    import lcc_pkg::*;
#(
    parameter int N_DEV      = 2,
    parameter int CH_PER_DEV = 8,
    parameter int SYS_NS     = 10,
    parameter int HALF_CYC   = 3,
    parameter int GAP_CYC    = 5,
    parameter int LATCH_CYC  = 5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        frame_valid,
    output logic                        frame_ready,
    input  logic [N_DEV*CH_PER_DEV-1:0] frame_data,
    input  logic                        blank_in,
    output logic                        sdata,
    output logic                        sclk,
    output logic                        latch,
    output logic                        oe_n,
    output logic                        done
);
    localparam int FRAME_W = N_DEV * CH_PER_DEV;

    // elaboration-time timing guard
    if (HALF_CYC < ns_cycles(HALF_MIN_NS, SYS_NS) ||
        HALF_CYC < ns_cycles(SETUP_MIN_NS, SYS_NS)) begin : g_bad_half
        $error("shift clock half period too short for the drivers");
    end
    if (GAP_CYC < ns_cycles(STROBE_MIN_NS, SYS_NS)) begin : g_bad_gap
        $error("gap before strobe too short for the drivers");
    end
    if (LATCH_CYC < ns_cycles(STROBE_MIN_NS, SYS_NS)) begin : g_bad_latch
        $error("strobe width too short for the drivers");
    end

    logic load, adv, oe_q;

    lcc_sequencer #(
        .W     (FRAME_W),
        .HALF  (HALF_CYC),
        .GAP   (GAP_CYC),
        .LATCH (LATCH_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .in_valid (frame_valid),
        .in_ready (frame_ready),
        .load     (load),
        .adv      (adv),
        .sclk     (sclk),
        .latch    (latch),
        .done     (done)
    );

    lcc_serializer #(
        .W (FRAME_W)
    ) u_ser (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .adv  (adv),
        .din  (frame_data),
        .sout (sdata)
    );

    always_ff @(posedge clk) begin
        if (rst) oe_q <= 1'b1;
        else     oe_q <= blank_in;
    end

    assign oe_n = oe_q;
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker (
    input logic clk,
    input logic rst,
    input logic frame_valid,
    input logic frame_ready,
    input logic blank_in,
    input logic sclk,
    input logic latch,
    input logic oe_n,
    input logic done
);
    assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame_ready) |=> !frame_ready);

    assert_sclk_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !frame_ready);

    assert_no_strobe_while_shifting_R5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !latch);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(latch) && !latch && frame_ready));

    assert_blank_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (oe_n == $past(blank_in)));
endmodule

bind led_chain_ctrl lcc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_ready (frame_ready),
    .blank_in    (blank_in),
    .sclk        (sclk),
    .latch       (latch),
    .oe_n        (oe_n),
    .done        (done)
);

// File: tb/led_chain_ctrl_tb.sv
module led_chain_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV   = 2;
    localparam int CH     = 8;
    localparam int W      = NDEV * CH;
    localparam int H      = 3;
    localparam int G      = 5;
    localparam int L      = 5;
    localparam int SHIFT_T = 2 * H * W;
    localparam int T_DONE  = SHIFT_T + G + L;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         frame_valid = 1'b0;
    logic [W-1:0] frame_data = '0;
    logic         blank_in = 1'b0;
    logic         frame_ready, sdata, sclk, latch, oe_n, done;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 0;
    logic blank_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    led_chain_ctrl #(
        .N_DEV(NDEV), .CH_PER_DEV(CH), .SYS_NS(CLK_PERIOD),
        .HALF_CYC(H), .GAP_CYC(G), .LATCH_CYC(L)
    ) u_dut (
        .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_ready(frame_ready),
        .frame_data(frame_data), .blank_in(blank_in), .sdata(sdata), .sclk(sclk),
        .latch(latch), .oe_n(oe_n), .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // send one frame and compare every cycle against computed windows
    task automatic run_frame(input logic [W-1:0] d, input bit junk, input bit blink);
        int wait_n = 0;
        @(negedge clk);
        frame_data  = d;
        frame_valid = 1'b1;
        while (!frame_ready && wait_n < 1000) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R1", "ready before accept", int'(frame_ready), 1);
        for (int t = 0; t <= T_DONE + 1; t++) begin
            int bi;
            int exp_sclk, exp_latch;
            @(negedge clk);
            bi        = t / (2 * H);
            exp_sclk  = (t < SHIFT_T && (t % (2 * H)) >= H) ? 1 : 0;
            exp_latch = (t >= SHIFT_T + G && t < SHIFT_T + G + L) ? 1 : 0;
            chk("R3", $sformatf("sclk t=%0d", t), int'(sclk), exp_sclk);
            if (t < SHIFT_T)
                chk("R2/R4", $sformatf("sdata t=%0d", t), int'(sdata), int'(d[W-1-bi]));
            chk("R5", $sformatf("latch t=%0d", t), int'(latch), exp_latch);
            chk("R6", $sformatf("done t=%0d", t), int'(done), (t == T_DONE) ? 1 : 0);
            chk("R1", $sformatf("ready t=%0d", t), int'(frame_ready), (t >= T_DONE) ? 1 : 0);
            chk("R7", $sformatf("oe_n t=%0d", t), int'(oe_n), int'(blank_prev));
            if (t == 0) begin
                frame_valid = junk;
                frame_data  = ~d;
            end
            if (t == SHIFT_T) frame_valid = 1'b0;
            blank_in   = (blink && (t % 7) < 3 && t < T_DONE) ? 1'b1 : 1'b0;
            blank_prev = blank_in;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: state under reset
        chk("R8", "oe_n in reset", int'(oe_n), 1);
        chk("R8", "ready in reset", int'(frame_ready), 1);
        chk("R8", "sclk in reset", int'(sclk), 0);
        chk("R8", "latch in reset", int'(latch), 0);
        chk("R8", "done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", "oe_n after reset", int'(oe_n), 0);
        chk("R8", "sdata after reset", int'(sdata), 0);
        chk("R8", "ready after reset", int'(frame_ready), 1);

        // R7: blank alone while idle
        blank_in = 1'b1;
        @(negedge clk);
        chk("R7", "oe_n blank set", int'(oe_n), 1);
        blank_in = 1'b0;
        @(negedge clk);
        chk("R7", "oe_n blank clear", int'(oe_n), 0);
        blank_prev = 1'b0;

        run_frame('0, 1'b0, 1'b0);
        run_frame('1, 1'b1, 1'b0);
        run_frame(16'hA5C3, 1'b1, 1'b1);
        run_frame(16'h5555, 1'b0, 1'b1);
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] one_hot;
            one_hot = '0;
            one_hot[k] = 1'b1;
            run_frame(one_hot, k[0], k[1]);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule